// File: doc/BRIEF.md
# Cumulative-Boundary Display Timing Generator

This block drives a parallel RGB panel's horizontal sync, vertical sync and data-enable lines from the pixel clock. A horizontal counter and a vertical counter run over one full frame. Each timing value is programmed as a running boundary measured from the first sync pixel, not as a separate porch length. The horizontal sync field holds the sync width minus one. The back-porch boundary is that field plus the back porch. The active boundary adds the visible size to that, and the total adds the front porch on top. The counters are compared against these boundaries directly, so no adders sit in the decode path.

The four configuration words share one layout. The horizontal value sits in bits 27:16 and the vertical value in bits 10:0. A control word holds the run bit and four polarity selects. The block also reports the live counter pair as a position word. It gives two one-cycle strobes at the first pixel of a line: one when vertical blanking starts, and one when the line number matches a programmed line.

Top module: `acc_timing_gen`

## Requirements
- R1: While the run bit is clear, both counters are held at zero. HS, VS and DE sit at their inactive levels, and both strobes stay low.
- R2: With the run bit set, the horizontal count (X) rises by one per clock from 0 up to the horizontal total, inclusive. From that value it returns to 0.
- R3: The vertical count (Y) changes only on a clock where X returns to 0. It then rises by one, and from the vertical total it returns to 0.
- R4: HS is asserted while X is no greater than the horizontal sync field (bits 27:16 of the sync word). VS is asserted while Y is no greater than the vertical sync field (bits 10:0).
- R5: DE is asserted only when both of these hold. X is above the horizontal back-porch boundary and no greater than the horizontal active boundary. Y is above the vertical back-porch boundary and no greater than the vertical active boundary.
- R6: In the control word, bit 31 selects the HS level, bit 30 the VS level and bit 29 the DE level. A 1 makes that output active-high and a 0 makes it active-low. The inactive level is the inverse of the active level.
- R7: The pixel-clock edge select output always equals control bit 28 (1 = sample on the falling edge).
- R8: The position output carries X zero-extended in bits 31:16 and Y zero-extended in bits 15:0.
- R9: The line-match strobe is high for one clock when the run bit is set, X is 0 and Y equals the line-position input.
- R10: The blanking strobe is high for one clock when the run bit is set, X is 0 and Y equals the vertical active boundary plus 1. If that line lies beyond the vertical total, it never fires.
- R11: The run bit is bit 0 of the control word. Clearing it mid-frame returns both counters to zero on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ctrl_i | input | 32 | Run bit 0, pixel-clock edge bit 28, DE/VS/HS polarity bits 29/30/31 |
| cfg_sync_i | input | 32 | Sync length minus one (H 27:16, V 10:0) |
| cfg_bporch_i | input | 32 | Back-porch boundary (H 27:16, V 10:0) |
| cfg_active_i | input | 32 | Active boundary (H 27:16, V 10:0) |
| cfg_total_i | input | 32 | Last count of line and frame (H 27:16, V 10:0) |
| cfg_line_i | input | VW | Line number for the line-match strobe |
| hsync_o | output | 1 | Horizontal sync at the programmed polarity |
| vsync_o | output | 1 | Vertical sync at the programmed polarity |
| de_o | output | 1 | Data enable at the programmed polarity |
| pclk_inv_o | output | 1 | Pixel-clock edge select |
| pos_o | output | 32 | Position: X in 31:16, Y in 15:0 |
| vblank_o | output | 1 | Start-of-vertical-blanking strobe |
| line_o | output | 1 | Line-match strobe |

## Verification
The bench steps through every clock of several whole frames under two small timings. The second timing has no front porch on either axis and a zero-length back porch horizontally. A design that miscounts inclusive limits, off by one at a boundary, would show a short or long line, a sync one pixel wide or narrow, or DE opening on the back-porch boundary pixel.

The bench tries all sixteen polarity combinations. A swapped polarity bit shows up as an inverted line. It also clears the run bit mid-frame, where a design that only freezes the counters would resume from the old position. With the vertical active boundary plus one placed past the total, a blanking strobe that wraps or fires anyway is caught.

// File: rtl/tg_pkg.sv
package tg_pkg;
  localparam int unsigned RUN_BIT   = 0;
  localparam int unsigned PCLK_BIT  = 28;
  localparam int unsigned DE_POL    = 29;
  localparam int unsigned VS_POL    = 30;
  localparam int unsigned HS_POL    = 31;
  localparam int unsigned H_LSB     = 16;
  localparam int unsigned V_LSB     = 0;
  localparam int unsigned AXES      = 2;
  localparam int unsigned AX_H      = 0;
  localparam int unsigned AX_V      = 1;

  // Level driven on a pin given whether the function is asserted and
  // whether the pin is programmed active-high.
  function automatic logic pin_level(input logic asserted, input logic act_high);
    return ~(asserted ^ act_high);
  endfunction
endpackage

// File: rtl/tg_axis_cnt.sv
module tg_axis_cnt #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         step,
  input  logic [W-1:0] last,
  output logic [W-1:0] cnt,
  output logic         at_last
);
  logic [W-1:0] cnt_q, cnt_d;

  assign at_last = (cnt_q >= last);
  assign cnt     = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (!run) begin
      cnt_d = '0;
    end else if (step) begin
      cnt_d = at_last ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/tg_axis_win.sv
module tg_axis_win #(
  parameter int unsigned W = 12
) (
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] sync_end,
  input  logic [W-1:0] bp_end,
  input  logic [W-1:0] act_end,
  output logic         in_sync,
  output logic         in_act
);
  assign in_sync = (cnt <= sync_end);
  assign in_act  = (cnt > bp_end) && (cnt <= act_end);
endmodule

// File: rtl/tg_pol_out.sv
module tg_pol_out (
  input  logic run,
  input  logic hs_on,
  input  logic vs_on,
  input  logic de_on,
  input  logic hs_high,
  input  logic vs_high,
  input  logic de_high,
  output logic hsync,
  output logic vsync,
  output logic de
);
  import tg_pkg::*;

  assign hsync = pin_level(run & hs_on, hs_high);
  assign vsync = pin_level(run & vs_on, vs_high);
  assign de    = pin_level(run & de_on, de_high);
endmodule

// File: rtl/acc_timing_gen.sv
module acc_timing_gen #(
  parameter int unsigned HW = 12,
  parameter int unsigned VW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [31:0]   cfg_ctrl_i,
  input  logic [31:0]   cfg_sync_i,
  input  logic [31:0]   cfg_bporch_i,
  input  logic [31:0]   cfg_active_i,
  input  logic [31:0]   cfg_total_i,
  input  logic [VW-1:0] cfg_line_i,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic          pclk_inv_o,
  output logic [31:0]   pos_o,
  output logic          vblank_o,
  output logic          line_o
);
  import tg_pkg::*;

  localparam int unsigned CW = (HW > VW) ? HW : VW;

  logic                    run;
  logic [AXES-1:0][CW-1:0] f_sync, f_bp, f_act, f_tot, cnt;
  logic [AXES-1:0]         step, at_last, in_sync, in_act;
  logic                    col0;
  logic                    unused_cfg;

  assign run        = cfg_ctrl_i[RUN_BIT];
  assign unused_cfg = ^{cfg_ctrl_i, cfg_sync_i, cfg_bporch_i, cfg_active_i, cfg_total_i};

  // Field extraction, zero-extended to the shared counter width.
  assign f_sync[AX_H] = CW'(cfg_sync_i[H_LSB +: HW]);
  assign f_sync[AX_V] = CW'(cfg_sync_i[V_LSB +: VW]);
  assign f_bp[AX_H]   = CW'(cfg_bporch_i[H_LSB +: HW]);
  assign f_bp[AX_V]   = CW'(cfg_bporch_i[V_LSB +: VW]);
  assign f_act[AX_H]  = CW'(cfg_active_i[H_LSB +: HW]);
  assign f_act[AX_V]  = CW'(cfg_active_i[V_LSB +: VW]);
  assign f_tot[AX_H]  = CW'(cfg_total_i[H_LSB +: HW]);
  assign f_tot[AX_V]  = CW'(cfg_total_i[V_LSB +: VW]);

  // Horizontal counts every clock; vertical counts on the horizontal wrap.
  assign step[AX_H] = 1'b1;
  assign step[AX_V] = at_last[AX_H];

  for (genvar ax = 0; ax < AXES; ax++) begin : g_axis
    tg_axis_cnt #(.W(CW)) cnt_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .step    (step[ax]),
      .last    (f_tot[ax]),
      .cnt     (cnt[ax]),
      .at_last (at_last[ax])
    );

    tg_axis_win #(.W(CW)) win_i (
      .cnt      (cnt[ax]),
      .sync_end (f_sync[ax]),
      .bp_end   (f_bp[ax]),
      .act_end  (f_act[ax]),
      .in_sync  (in_sync[ax]),
      .in_act   (in_act[ax])
    );
  end

  tg_pol_out pol_i (
    .run     (run),
    .hs_on   (in_sync[AX_H]),
    .vs_on   (in_sync[AX_V]),
    .de_on   (in_act[AX_H] & in_act[AX_V]),
    .hs_high (cfg_ctrl_i[HS_POL]),
    .vs_high (cfg_ctrl_i[VS_POL]),
    .de_high (cfg_ctrl_i[DE_POL]),
    .hsync   (hsync_o),
    .vsync   (vsync_o),
    .de      (de_o)
  );

  assign pclk_inv_o = cfg_ctrl_i[PCLK_BIT];
  assign pos_o      = {16'(cnt[AX_H]), 16'(cnt[AX_V])};

  assign col0     = run && (cnt[AX_H] == '0);
  assign line_o   = col0 && (cnt[AX_V] == CW'(cfg_line_i));
  assign vblank_o = col0 &&
                    ({1'b0, cnt[AX_V]} == ({1'b0, f_act[AX_V]} + (CW+1)'(1)));
endmodule

// File: rtl/tg_checker.sv
module tg_checker #(
  parameter int unsigned HW = 12,
  parameter int unsigned VW = 11
) (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] cfg_ctrl_i,
  input logic [31:0] cfg_total_i,
  input logic        hsync_o,
  input logic        vsync_o,
  input logic        de_o,
  input logic [31:0] pos_o,
  input logic        vblank_o,
  input logic        line_o
);
  logic        run;
  logic [15:0] x, y, tw;
  logic        unused_chk;

  assign run        = cfg_ctrl_i[0];
  assign x          = pos_o[31:16];
  assign y          = pos_o[15:0];
  assign tw         = 16'(cfg_total_i[16 +: HW]);
  assign unused_chk = ^{cfg_ctrl_i, cfg_total_i, VW};

  assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pos_o == 32'd0));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (hsync_o == ~cfg_ctrl_i[31] && vsync_o == ~cfg_ctrl_i[30] &&
              de_o == ~cfg_ctrl_i[29] && !vblank_o && !line_o));

  assert_x_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    x <= tw);

  assert_x_wraps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && x == tw) |=> (!run || x == 16'd0));

  assert_y_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && x != tw) |=> (!run || y == $past(y)));

  assert_de_outside_sync_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (de_o == cfg_ctrl_i[29]) |-> (hsync_o != cfg_ctrl_i[31]));

  assert_line_col0_R9: assert property (@(posedge clk) disable iff (!rst_n)
    line_o |-> (x == 16'd0));

  assert_blank_col0_R10: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_o |-> (x == 16'd0));
endmodule

bind acc_timing_gen tg_checker #(.HW(HW), .VW(VW)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_ctrl_i  (cfg_ctrl_i),
  .cfg_total_i (cfg_total_i),
  .hsync_o     (hsync_o),
  .vsync_o     (vsync_o),
  .de_o        (de_o),
  .pos_o       (pos_o),
  .vblank_o    (vblank_o),
  .line_o      (line_o)
);

// File: tb/acc_timing_gen_tb_top.sv
module acc_timing_gen_tb_top;
  localparam int unsigned HW = 12;
  localparam int unsigned VW = 11;

  logic          clk;
  logic          rst_n;
  logic [31:0]   ctrl, w_sync, w_bp, w_act, w_tot;
  logic [VW-1:0] line_sel;
  logic          hsync, vsync, de, pclk_inv, vblank, line_hit;
  logic [31:0]   pos;

  int n_chk  = 0;
  int n_fail = 0;
  int hsf, hbp, haw, htw, vsf, vbp, vah, vth;
  int ex, ey;

  acc_timing_gen #(.HW(HW), .VW(VW)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_ctrl_i   (ctrl),
    .cfg_sync_i   (w_sync),
    .cfg_bporch_i (w_bp),
    .cfg_active_i (w_act),
    .cfg_total_i  (w_tot),
    .cfg_line_i   (line_sel),
    .hsync_o      (hsync),
    .vsync_o      (vsync),
    .de_o         (de),
    .pclk_inv_o   (pclk_inv),
    .pos_o        (pos),
    .vblank_o     (vblank),
    .line_o       (line_hit)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (x=%0d y=%0d)", what, act, exp, ex, ey);
    end
  endtask

  task automatic load_cfg();
    w_sync = 32'((hsf << 16) | vsf);
    w_bp   = 32'((hbp << 16) | vbp);
    w_act  = 32'((haw << 16) | vah);
    w_tot  = 32'((htw << 16) | vth);
  endtask

  task automatic compare_all();
    logic run, hs_on, vs_on, de_on, ln, vb;
    run   = ctrl[0];
    hs_on = run && (ex <= hsf);
    vs_on = run && (ey <= vsf);
    de_on = run && (ex > hbp) && (ex <= haw) && (ey > vbp) && (ey <= vah);
    ln    = run && (ex == 0) && (ey == int'(line_sel));
    vb    = run && (ex == 0) && (ey == vah + 1);
    if (!run) begin
      check("R1 idle position", pos, 32'd0);
    end
    check("R2 X count", {16'd0, pos[31:16]}, 32'(ex));
    check("R3 Y count", {16'd0, pos[15:0]}, 32'(ey));
    check("R8 position packing", pos, {16'(ex), 16'(ey)});
    check("R4/R6 hsync", {31'd0, hsync}, {31'd0, hs_on ? ctrl[31] : ~ctrl[31]});
    check("R4/R6 vsync", {31'd0, vsync}, {31'd0, vs_on ? ctrl[30] : ~ctrl[30]});
    check("R5/R6 data enable", {31'd0, de}, {31'd0, de_on ? ctrl[29] : ~ctrl[29]});
    check("R7 pixel clock edge", {31'd0, pclk_inv}, {31'd0, ctrl[28]});
    check("R9 line match", {31'd0, line_hit}, {31'd0, ln});
    check("R10 blanking strobe", {31'd0, vblank}, {31'd0, vb});
  endtask

  // One clock: advance the reference counters by the run bit seen at the edge.
  task automatic tick();
    @(posedge clk);
    if (ctrl[0]) begin
      if (ex >= htw) begin
        ex = 0;
        ey = (ey >= vth) ? 0 : ey + 1;
      end else begin
        ex = ex + 1;
      end
    end else begin
      ex = 0;
      ey = 0;
    end
    @(negedge clk);
    compare_all();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    ctrl  = 32'd0;
    hsf = 1; hbp = 3; haw = 9; htw = 11;
    vsf = 0; vbp = 2; vah = 6; vth = 8;
    load_cfg();
    line_sel = VW'(vah + 1);
    ex = 0;
    ey = 0;
    repeat (3) @(negedge clk);
    // R1: reset state with run bit clear, default active-low pins idle high
    compare_all();
    rst_n = 1'b1;
    tick();
    tick();

    // R11: run bit starts counting; sweep all polarity combinations (R6, R7)
    for (int p = 0; p < 16; p++) begin
      ctrl = (32'(p) << 28) | 32'd1;
      line_sel = (p < 8) ? VW'(vah + 1) : VW'(3);
      for (int c = 0; c < 2 * (htw + 1) * (vth + 1); c++) tick();
    end

    // R11/R1: clear the run bit mid-frame; counters must return to zero
    for (int c = 0; c < 37; c++) tick();
    ctrl = 32'hA000_0000;
    for (int c = 0; c < 6; c++) tick();

    // Second timing: no front porches, no horizontal back porch.
    // Blanking line (vah+1) lies past the vertical total, so R10 never fires.
    hsf = 0; hbp = 0; haw = 4; htw = 4;
    vsf = 1; vbp = 1; vah = 3; vth = 3;
    load_cfg();
    line_sel = VW'(0);
    tick();
    ctrl = 32'h0000_0001;
    for (int c = 0; c < 3 * (htw + 1) * (vth + 1); c++) tick();
    ctrl = 32'hF000_0001;
    line_sel = VW'(2);
    for (int c = 0; c < 2 * (htw + 1) * (vth + 1); c++) tick();
    ctrl = 32'd0;
    tick();
    tick();

    summary();
    $finish;
  end
endmodule